// File: doc/BRIEF.md
# Branch Trace Program Counter Rebuilder

This block turns a decoded stream of compressed branch-trace messages back into a running program counter, and emits a short event record each time execution reaches an address marked as interesting. Four message kinds arrive on one input: a sync that gives the full address, a direct-branch atom that says only whether the branch was taken, an indirect branch that gives only some bytes of the new address, and a context change.

Addresses come from a table of basic blocks loaded in advance through a simple write port. The table is indexed by the low address bits within the bank picked by the last context change. Each valid entry describes the block that starts at that index. It gives the target of the direct branch that ends the block, the block length in bytes for the fall-through path, a tracepoint flag and an event ID. A flagged hit produces a record with the ID and a timestamp. The timestamp is taken from the message when the message carries one, and from a local cycle counter otherwise.

Top module: `trace_rebuilder`

## Requirements
- R1: After reset, `locked`, `miss_err` and `tp_valid` are 0, `rec_pc` is 0 and the bank is 0.
- R2: Until the first sync (kind 0) is accepted, every other message is discarded: `rec_pc` stays unchanged and no event is emitted.
- R3: A sync loads `rec_pc` with `msg_addr`, sets `locked`, clears `miss_err`, and becomes the base for later indirect branches.
- R4: An atom (kind 1) with `msg_taken`=1 moves `rec_pc` to the target stored in the entry of the current address.
- R5: An atom with `msg_taken`=0 moves `rec_pc` to the current address plus the entry's block length.
- R6: An indirect branch (kind 2) builds the new address from the last sync or indirect address. Byte i (bits 8i+7..8i) is taken from `msg_addr` where `msg_bmask[i]`=1 and kept from that base otherwise. Atom moves do not change the base.
- R7: An event is emitted only when the new address has a valid entry with its tracepoint flag set, and `tp_id` is that entry's ID.
- R8: `tp_ts` equals `msg_ts` when `msg_ts_valid`=1. Otherwise it equals the number of clock edges since reset was released, counted at the edge that accepts the message.
- R9: A context message (kind 3) selects bank `msg_addr[BW-1:0]` for all later lookups and leaves `rec_pc` unchanged. Lookups use index `{bank, addr[IDX_W-1:0]}`.
- R10: A new address with no valid entry, or an atom at an address with no valid entry, sets the sticky `miss_err`. `rec_pc` takes the missed address, and no event is emitted. While `miss_err` is set, non-sync messages are ignored until a sync clears it.
- R11: `rec_pc`, `miss_err` and the event outputs update one clock after the message is accepted, and `tp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| msg_valid | input | 1 | Message present this cycle |
| msg_kind | input | 2 | 0 sync, 1 atom, 2 indirect, 3 context |
| msg_taken | input | 1 | Atom outcome, 1 = taken |
| msg_addr | input | AW | Full, partial or context value |
| msg_bmask | input | AW/8 | Byte mask for indirect branches |
| msg_ts_valid | input | 1 | Message carries a timestamp |
| msg_ts | input | TW | Message timestamp |
| tbl_we | input | 1 | Table write strobe |
| tbl_bank | input | BW | Bank written |
| tbl_idx | input | IDX_W | Entry written |
| tbl_valid | input | 1 | Entry present |
| tbl_tp | input | 1 | Tracepoint flag |
| tbl_id | input | IDW | Event ID |
| tbl_target | input | AW | Taken-branch target |
| tbl_len | input | LW | Block length in bytes |
| tp_valid | output | 1 | Event pulse |
| tp_id | output | IDW | Event ID |
| tp_ts | output | TW | Event timestamp |
| rec_pc | output | AW | Rebuilt program counter |
| locked | output | 1 | A sync has been seen |
| miss_err | output | 1 | Sticky lookup-miss flag |

## Verification
The message stream covers each kind in turn. Atoms taken and not taken separate the target path from the fall-through path. Two indirect branches are sent after an atom has moved the address, so that merging into the last full address can be told apart from merging into the current address. A context switch followed by syncs to the same address in both banks shows that the bank selects the entry. A run into an empty entry, a sync to an empty entry and messages sent while the miss flag is set show the sticky suppression and how a sync clears it. Timestamps are checked both with and without a timestamp in the message.

// File: rtl/trace_rebuilder.sv
module trace_rebuilder #(
  parameter int AW = 32,
  parameter int IDX_W = 4,
  parameter int BANKS = 2,
  parameter int IDW = 8,
  parameter int TW = 16,
  parameter int LW = 4,
  localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [1:0]       msg_kind,
  input  logic             msg_taken,
  input  logic [AW-1:0]    msg_addr,
  input  logic [AW/8-1:0]  msg_bmask,
  input  logic             msg_ts_valid,
  input  logic [TW-1:0]    msg_ts,
  input  logic             tbl_we,
  input  logic [BW-1:0]    tbl_bank,
  input  logic [IDX_W-1:0] tbl_idx,
  input  logic             tbl_valid,
  input  logic             tbl_tp,
  input  logic [IDW-1:0]   tbl_id,
  input  logic [AW-1:0]    tbl_target,
  input  logic [LW-1:0]    tbl_len,
  output logic             tp_valid,
  output logic [IDW-1:0]   tp_id,
  output logic [TW-1:0]    tp_ts,
  output logic [AW-1:0]    rec_pc,
  output logic             locked,
  output logic             miss_err
);
  localparam int NB = AW / 8;
  localparam int AIW = BW + IDX_W;
  localparam int DEPTH = 1 << AIW;
  localparam logic [1:0] K_SYNC = 2'd0, K_ATOM = 2'd1, K_IND = 2'd2, K_CTX = 2'd3;

  logic [DEPTH-1:0] e_val, e_tp;
  logic [IDW-1:0]   e_id  [DEPTH];
  logic [AW-1:0]    e_tgt [DEPTH];
  logic [LW-1:0]    e_len [DEPTH];

  logic [AW-1:0] base, merged, npc;
  logic [BW-1:0] bank;
  logic [TW-1:0] now;
  logic          accept, moves, bad, hit;

  wire [AIW-1:0] wr_i  = {tbl_bank, tbl_idx};
  wire [AIW-1:0] cur_i = {bank, rec_pc[IDX_W-1:0]};
  wire [AIW-1:0] new_i = {bank, npc[IDX_W-1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      e_val <= '0;
      e_tp  <= '0;
    end else if (tbl_we) begin
      e_val[wr_i] <= tbl_valid;
      e_tp[wr_i]  <= tbl_tp;
    end

  always_ff @(posedge clk)
    if (tbl_we) begin
      e_id[wr_i]  <= tbl_id;
      e_tgt[wr_i] <= tbl_target;
      e_len[wr_i] <= tbl_len;
    end

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[8*b +: 8] = msg_bmask[b] ? msg_addr[8*b +: 8] : base[8*b +: 8];
  end

  assign accept = msg_valid && (msg_kind == K_SYNC || (locked && !miss_err));
  assign hit = e_val[new_i];

  always_comb begin
    npc = rec_pc;
    moves = 1'b0;
    bad = 1'b0;
    case (msg_kind)
      K_SYNC: begin npc = msg_addr; moves = 1'b1; end
      K_ATOM: begin
        if (!e_val[cur_i]) bad = 1'b1;
        else begin
          npc = msg_taken ? e_tgt[cur_i] : rec_pc + AW'(e_len[cur_i]);
          moves = 1'b1;
        end
      end
      K_IND: begin npc = merged; moves = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rec_pc   <= '0;
      base     <= '0;
      bank     <= '0;
      locked   <= 1'b0;
      miss_err <= 1'b0;
      now      <= '0;
      tp_valid <= 1'b0;
      tp_id    <= '0;
      tp_ts    <= '0;
    end else begin
      now      <= now + 1'b1;
      tp_valid <= 1'b0;
      if (accept) begin
        if (moves) rec_pc <= npc;
        if (msg_kind == K_SYNC || msg_kind == K_IND) base <= npc;
        if (msg_kind == K_SYNC) locked <= 1'b1;
        if (msg_kind == K_CTX) bank <= msg_addr[BW-1:0];
        miss_err <= bad || (moves && !hit);
        if (moves && hit && e_tp[new_i]) begin
          tp_valid <= 1'b1;
          tp_id    <= e_id[new_i];
          tp_ts    <= msg_ts_valid ? msg_ts : now;
        end
      end
    end
endmodule

// File: rtl/trace_rebuilder_chk.sv
module trace_rebuilder_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          msg_valid,
  input logic [1:0]    msg_kind,
  input logic [AW-1:0] msg_addr,
  input logic          tp_valid,
  input logic          locked,
  input logic          miss_err,
  input logic [AW-1:0] rec_pc
);
  wire is_sync = msg_valid && msg_kind == 2'd0;

  assert_sync_loads_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_sync |=> rec_pc == $past(msg_addr));

  assert_ctx_keeps_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == 2'd3) |=> $stable(rec_pc));

  assert_miss_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_err && !is_sync) |=> miss_err);

  assert_no_event_on_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tp_valid |-> !miss_err);

  assert_no_event_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !tp_valid);

  assert_pc_frozen_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !is_sync) |=> $stable(rec_pc));

  assert_event_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_valid && !msg_valid) |=> !tp_valid);
endmodule

bind trace_rebuilder trace_rebuilder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_kind(msg_kind),
  .msg_addr(msg_addr), .tp_valid(tp_valid), .locked(locked),
  .miss_err(miss_err), .rec_pc(rec_pc)
);

// File: tb/trace_rebuilder_bench.sv
module trace_rebuilder_bench;
  logic clk = 0, rst_n = 0;
  logic msg_valid = 0, msg_taken = 0, msg_ts_valid = 0;
  logic [1:0] msg_kind = 0;
  logic [31:0] msg_addr = 0;
  logic [3:0] msg_bmask = 0;
  logic [15:0] msg_ts = 0;
  logic tbl_we = 0, tbl_bank = 0, tbl_valid = 0, tbl_tp = 0;
  logic [3:0] tbl_idx = 0, tbl_len = 0;
  logic [7:0] tbl_id = 0;
  logic [31:0] tbl_target = 0;
  logic tp_valid, locked, miss_err;
  logic [7:0] tp_id;
  logic [15:0] tp_ts;
  logic [31:0] rec_pc;

  int total = 0, bad = 0, cyc = 0, drive_cyc = 0;

  trace_rebuilder u_trace_rebuilder (.*);

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc++;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic bk, logic [3:0] idx, logic v, logic tp, logic [7:0] id,
                    logic [31:0] tgt, logic [3:0] len);
    @(negedge clk);
    tbl_we = 1; tbl_bank = bk; tbl_idx = idx; tbl_valid = v; tbl_tp = tp;
    tbl_id = id; tbl_target = tgt; tbl_len = len;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic send(logic [1:0] k, logic tk, logic [31:0] a, logic [3:0] m,
                      logic tsv, logic [15:0] ts);
    @(negedge clk);
    msg_valid = 1; msg_kind = k; msg_taken = tk; msg_addr = a; msg_bmask = m;
    msg_ts_valid = tsv; msg_ts = ts;
    drive_cyc = cyc;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic expect_state(string req, logic [31:0] pc, logic tv, logic [7:0] id, logic ms);
    chk({req, " pc"}, rec_pc, pc);
    chk({req, " tp_valid"}, tp_valid, tv);
    if (tv) chk({req, " tp_id"}, tp_id, id);
    chk({req, " miss"}, miss_err, ms);
  endtask

  task automatic t_reset;
    chk("R1 locked", locked, 0);
    chk("R1 miss", miss_err, 0);
    chk("R1 tp_valid", tp_valid, 0);
    chk("R1 pc", rec_pc, 0);
  endtask

  task automatic t_prelock;
    send(1, 1, 0, 0, 0, 0);
    expect_state("R2 atom before sync", 0, 0, 0, 0);
    send(2, 0, 32'h1000_0001, 4'hF, 0, 0);
    expect_state("R2 indirect before sync", 0, 0, 0, 0);
    chk("R2 locked", locked, 0);
  endtask

  task automatic t_sync_atoms;
    send(0, 0, 32'h1000_0001, 0, 1, 16'h1234);
    expect_state("R3 R11 sync", 32'h1000_0001, 1, 8'h11, 0);
    chk("R8 message ts", tp_ts, 16'h1234);
    chk("R3 locked", locked, 1);
    send(1, 1, 0, 0, 0, 0);
    expect_state("R4 taken, R7 unflagged", 32'h1000_0005, 0, 0, 0);
    send(1, 0, 0, 0, 0, 0);
    expect_state("R5 not taken", 32'h1000_0007, 1, 8'h77, 0);
    chk("R8 local ts", tp_ts, 16'(drive_cyc));
    @(negedge clk);
    chk("R11 pulse", tp_valid, 0);
  endtask

  task automatic t_indirect;
    send(2, 0, 32'h0000_2000, 4'b0010, 0, 0);
    expect_state("R6 merge into sync base", 32'h1000_2001, 1, 8'h11, 0);
    send(2, 0, 32'hAABB_000C, 4'b1101, 0, 0);
    expect_state("R6 merge into indirect base", 32'hAABB_200C, 1, 8'hCC, 0);
  endtask

  task automatic t_context;
    send(3, 0, 32'h1, 0, 0, 0);
    expect_state("R9 context keeps pc", 32'hAABB_200C, 0, 0, 0);
    send(0, 0, 32'h0000_0005, 0, 0, 0);
    expect_state("R9 bank 1 entry", 32'h0000_0005, 1, 8'h55, 0);
    chk("R8 local ts bank1", tp_ts, 16'(drive_cyc));
    send(3, 0, 32'h0, 0, 0, 0);
    send(0, 0, 32'h0000_0005, 0, 0, 0);
    expect_state("R9 R7 bank 0 unflagged", 32'h0000_0005, 0, 0, 0);
  endtask

  task automatic t_miss;
    send(0, 0, 32'h1000_0007, 0, 0, 0);
    expect_state("R3 resync", 32'h1000_0007, 1, 8'h77, 0);
    send(1, 0, 0, 0, 0, 0);
    expect_state("R10 miss raised", 32'h1000_0008, 0, 0, 1);
    send(2, 0, 32'h0000_0001, 4'b0001, 0, 0);
    expect_state("R10 indirect ignored", 32'h1000_0008, 0, 0, 1);
    send(1, 1, 0, 0, 0, 0);
    expect_state("R10 atom ignored", 32'h1000_0008, 0, 0, 1);
    send(0, 0, 32'h1000_0009, 0, 1, 16'hBEEF);
    expect_state("R10 sync clears", 32'h1000_0009, 1, 8'h99, 0);
    chk("R8 message ts after miss", tp_ts, 16'hBEEF);
    send(0, 0, 32'h0000_0003, 0, 0, 0);
    expect_state("R10 sync to empty entry", 32'h0000_0003, 0, 0, 1);
    send(0, 0, 32'h1000_0002, 0, 0, 0);
    expect_state("R10 R7 sync valid unflagged", 32'h1000_0002, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    wr(0, 4'h1, 1, 1, 8'h11, 32'h1000_0005, 4'd4);
    wr(0, 4'h5, 1, 0, 8'h05, 32'h1000_0009, 4'd2);
    wr(0, 4'h7, 1, 1, 8'h77, 32'h1000_0001, 4'd1);
    wr(0, 4'h9, 1, 1, 8'h99, 32'h1000_0001, 4'd4);
    wr(0, 4'hC, 1, 1, 8'hCC, 32'h1000_0001, 4'd4);
    wr(0, 4'h2, 1, 0, 8'h02, 32'h1000_0001, 4'd4);
    wr(1, 4'h5, 1, 1, 8'h55, 32'h0000_0001, 4'd4);
    t_prelock;
    t_sync_atoms;
    t_indirect;
    t_context;
    t_miss;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule